// File: doc/BRIEF.md
# Multi-Block Erase Scheduler with Suspend

This block sequences the erasure of a set of flash blocks. A block-erase confirm, carrying a block index, opens a collection window measured in microsecond ticks. Further confirms that arrive while the window is open add their blocks to the set and restart the window. When the window runs out without a new confirm, the timer-expired flag rises. From then on, the scheduler works through the selected blocks in ascending index order. A chip-erase request made while idle skips the window. It selects every block at once.

Each block passes through two phases with programmable tick counts: a precondition phase, in which the cells are driven to all zeros, and an erase phase, in which they are driven to all ones. Blocks whose protection bit is set when the window closes are dropped from the set. If nothing is left after that, the block stays busy for a fixed number of ticks and then returns to idle. A suspend request takes effect at a tick boundary and keeps the current block and phase progress. A resume continues from exactly that point. A failure input raised during a phase sets a sticky error flag, and the remaining blocks are still processed.

Top module: `mblk_erase_sched`

## Requirements
- R1: After reset, ready_o=1, tmr_exp_o=0, done_o=0, err_o=0 and erasing_o=0.
- R2: While idle, a confirm (cfm_i=1) with cfm_blk_i below NB opens the window. On the next cycle ready_o=0, tmr_exp_o=0, and erasing_o holds only bit cfm_blk_i. A confirm with an index of NB or more is ignored.
- R3: Each valid confirm in the window adds its block and restarts the count. The window expires on the WIN_TICKS-th tick after the last confirm. tmr_exp_o is 1 from expiry until the return to idle.
- R4: Each block takes max(pre_ticks_i,1) ticks and then max(ers_ticks_i,1) ticks. Blocks are processed lowest index first. The bit of a block is cleared from erasing_o on the tick that ends its erase phase.
- R5: Blocks whose prot_i bit is set at window expiry are removed from erasing_o and skipped.
- R6: If no selected block is unprotected at expiry, the block stays busy (ready_o=0, tmr_exp_o=1) for NOP_TICKS ticks and then returns to idle.
- R7: After expiry, confirm and chip-erase requests are ignored.
- R8: A suspend request (susp_i) during a phase takes effect on the first tick at or after it. While suspended, ready_o=1, tmr_exp_o=1, and erasing_o and the phase progress are held. The resume edge (resume_i) counts no tick, and progress continues from where it stopped.
- R9: A chip-erase request (chip_i) while idle selects all unprotected blocks and starts the first phase on the same edge, with no window. chip_i has priority over cfm_i.
- R10: fail_i high during a phase sets err_o, which stays set while the remaining blocks are processed. err_o is cleared only when a new erase is accepted from idle.
- R11: On the return to idle, done_o is high for exactly one cycle, with ready_o=1 and erasing_o=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle microsecond tick |
| cfm_i | input | 1 | Block-erase confirm pulse |
| cfm_blk_i | input | $clog2(NB) | Block index of the confirm |
| chip_i | input | 1 | Chip-erase request pulse |
| susp_i | input | 1 | Suspend request pulse |
| resume_i | input | 1 | Resume request pulse |
| fail_i | input | 1 | Phase failure indication |
| prot_i | input | NB | Per-block protection mask |
| pre_ticks_i | input | CW | Precondition phase length in ticks |
| ers_ticks_i | input | CW | Erase phase length in ticks |
| ready_o | output | 1 | 1 when idle or suspended |
| erasing_o | output | NB | Blocks still to be erased |
| tmr_exp_o | output | 1 | Window expired, erase under way |
| done_o | output | 1 | One-cycle pulse on return to idle |
| err_o | output | 1 | Sticky failure flag |

## Verification
All results are registered. A stimulus that is sampled on edge E0 shows up on the outputs after E0, counted as cycle 0. With a tick on every cycle, the timer-expired flag rises at cycle WIN_TICKS, a block's erasing bit clears (WIN_TICKS + n·(pre+ers)) cycles after the last confirm, and done_o pulses at that same cycle for the final block. Suspend adds exactly one stalled cycle for each edge from the suspend edge up to and including the resume edge. Each bench task drives inputs on a falling edge and advances a counted number of falling edges. It then samples each output at the computed cycle and also one cycle before it, so that a response that is early or late by one cycle is caught.

// File: rtl/mbe_pkg.sv
`timescale 1ns/1ps
package mbe_pkg;

  typedef enum logic [2:0] {
    S_IDLE = 3'd0,
    S_WIN  = 3'd1,
    S_PRE  = 3'd2,
    S_ERS  = 3'd3,
    S_NOP  = 3'd4,
    S_SUSP = 3'd5
  } mbe_state_e;

  // True when one more step reaches the limit (a limit of zero acts as one).
  function automatic logic at_limit(input int unsigned cnt, input int unsigned lim);
    return (cnt + 1) >= lim;
  endfunction

endpackage

// File: rtl/mbe_window_timer.sv
`timescale 1ns/1ps
module mbe_window_timer #(
  parameter int WIN_TICKS = 70
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart_i,
  input  logic run_i,
  input  logic tick_i,
  output logic expire_o
);
  import mbe_pkg::*;

  localparam int WW = $clog2(WIN_TICKS + 1);

  logic [WW-1:0] cnt_q;

  assign expire_o = run_i && tick_i && !restart_i &&
                    at_limit(32'(cnt_q), WIN_TICKS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (restart_i)        cnt_q <= '0;
    else if (run_i && tick_i)  cnt_q <= expire_o ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/mbe_phase_counter.sv
`timescale 1ns/1ps
module mbe_phase_counter #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          step_i,
  input  logic [CW-1:0] lim_i,
  output logic          last_o
);
  import mbe_pkg::*;

  logic [CW-1:0] cnt_q;

  assign last_o = step_i && at_limit(32'(cnt_q), 32'(lim_i));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (clear_i) cnt_q <= '0;
    else if (step_i)  cnt_q <= last_o ? '0 : cnt_q + 1'b1;
  end

endmodule

// File: rtl/mblk_erase_sched.sv
`timescale 1ns/1ps
module mblk_erase_sched #(
  parameter int NB        = 19,
  parameter int WIN_TICKS = 70,
  parameter int NOP_TICKS = 100,
  parameter int CW        = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  tick_i,
  input  logic                  cfm_i,
  input  logic [$clog2(NB)-1:0] cfm_blk_i,
  input  logic                  chip_i,
  input  logic                  susp_i,
  input  logic                  resume_i,
  input  logic                  fail_i,
  input  logic [NB-1:0]         prot_i,
  input  logic [CW-1:0]         pre_ticks_i,
  input  logic [CW-1:0]         ers_ticks_i,
  output logic                  ready_o,
  output logic [NB-1:0]         erasing_o,
  output logic                  tmr_exp_o,
  output logic                  done_o,
  output logic                  err_o
);
  import mbe_pkg::*;

  localparam int BW = $clog2(NB);

  function automatic logic [NB-1:0] blk_bit(input logic [BW-1:0] idx);
    return NB'(1) << idx;
  endfunction

  function automatic logic [BW-1:0] lowest_blk(input logic [NB-1:0] m);
    logic [BW-1:0] r;
    r = '0;
    for (int i = NB - 1; i >= 0; i--) if (m[i]) r = BW'(i);
    return r;
  endfunction

  mbe_state_e    st_q;
  logic [NB-1:0] sel_q;
  logic [BW-1:0] cur_q;
  logic          sv_ers_q, susp_pend_q, done_q, err_q;

  // Named internal events
  logic          cfm_ok, active, susp_req, susp_take, phase_step, phase_last;
  logic          win_clr, win_exp, start_evt, blk_fin;
  logic [NB-1:0] start_mask, rest_mask;
  logic [BW-1:0] nxt_idx;
  logic [CW-1:0] phase_lim;

  assign cfm_ok     = cfm_i && (32'(cfm_blk_i) < NB);
  assign active     = (st_q == S_PRE) || (st_q == S_ERS);
  assign susp_req   = susp_i || susp_pend_q;
  assign susp_take  = active && tick_i && susp_req;
  assign phase_step = tick_i && ((active && !susp_req) || (st_q == S_NOP));
  assign win_clr    = cfm_ok && ((st_q == S_WIN) || (st_q == S_IDLE && !chip_i));
  assign start_evt  = win_exp || (st_q == S_IDLE && chip_i);
  assign start_mask = (st_q == S_IDLE) ? ~prot_i : (sel_q & ~prot_i);
  assign rest_mask  = sel_q & ~blk_bit(cur_q);
  assign nxt_idx    = lowest_blk(start_evt ? start_mask : rest_mask);
  assign blk_fin    = (st_q == S_ERS) && phase_last;

  always_comb begin
    unique case (st_q)
      S_PRE:   phase_lim = pre_ticks_i;
      S_ERS:   phase_lim = ers_ticks_i;
      default: phase_lim = CW'(NOP_TICKS);
    endcase
  end

  mbe_window_timer #(.WIN_TICKS(WIN_TICKS)) win_i (
    .clk(clk), .rst_n(rst_n), .restart_i(win_clr),
    .run_i(st_q == S_WIN), .tick_i(tick_i), .expire_o(win_exp)
  );

  mbe_phase_counter #(.CW(CW)) ph_i (
    .clk(clk), .rst_n(rst_n), .clear_i(start_evt),
    .step_i(phase_step), .lim_i(phase_lim), .last_o(phase_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= S_IDLE;
      sel_q    <= '0;
      cur_q    <= '0;
      sv_ers_q <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (chip_i || cfm_ok) err_q <= 1'b0;
          if (chip_i) begin
            sel_q <= start_mask;
            if (|start_mask) begin st_q <= S_PRE; cur_q <= nxt_idx; end
            else st_q <= S_NOP;
          end else if (cfm_ok) begin
            sel_q <= blk_bit(cfm_blk_i);
            st_q  <= S_WIN;
          end
        end
        S_WIN: begin
          if (cfm_ok) sel_q <= sel_q | blk_bit(cfm_blk_i);
          else if (win_exp) begin
            sel_q <= start_mask;
            if (|start_mask) begin st_q <= S_PRE; cur_q <= nxt_idx; end
            else st_q <= S_NOP;
          end
        end
        S_PRE: begin
          if (susp_take)       begin st_q <= S_SUSP; sv_ers_q <= 1'b0; end
          else if (phase_last) st_q <= S_ERS;
        end
        S_ERS: begin
          if (susp_take) begin st_q <= S_SUSP; sv_ers_q <= 1'b1; end
          else if (blk_fin) begin
            sel_q <= rest_mask;
            if (|rest_mask) begin st_q <= S_PRE; cur_q <= nxt_idx; end
            else begin st_q <= S_IDLE; done_q <= 1'b1; end
          end
        end
        S_NOP: begin
          if (phase_last) begin st_q <= S_IDLE; done_q <= 1'b1; end
        end
        S_SUSP: begin
          if (resume_i) st_q <= sv_ers_q ? S_ERS : S_PRE;
        end
        default: st_q <= S_IDLE;
      endcase
      if (fail_i && active) err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   susp_pend_q <= 1'b0;
    else if (!active || susp_take) susp_pend_q <= 1'b0;
    else if (susp_i)              susp_pend_q <= 1'b1;
  end

  assign ready_o   = (st_q == S_IDLE) || (st_q == S_SUSP);
  assign tmr_exp_o = !((st_q == S_IDLE) || (st_q == S_WIN));
  assign erasing_o = sel_q;
  assign done_o    = done_q;
  assign err_o     = err_q;

endmodule

// File: rtl/mblk_erase_sched_chk.sv
`timescale 1ns/1ps
module mblk_erase_sched_chk #(
  parameter int NB = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ready_o,
  input logic [NB-1:0] erasing_o,
  input logic          tmr_exp_o,
  input logic          done_o,
  input logic          err_o,
  input logic          blk_fin
);

  p_done_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (ready_o && !tmr_exp_o && erasing_o == '0));

  p_no_growth_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_exp_o && $past(tmr_exp_o)) |-> ((erasing_o & ~$past(erasing_o)) == '0));

  p_susp_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_o && tmr_exp_o && $past(ready_o && tmr_exp_o)) |-> $stable(erasing_o));

  p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(err_o) && !err_o) |-> $past(ready_o && !tmr_exp_o));

  p_one_fin_r4: assert property (@(posedge clk) disable iff (!rst_n)
    blk_fin |=> ($countones(erasing_o) == $countones($past(erasing_o)) - 1));

endmodule

bind mblk_erase_sched mblk_erase_sched_chk #(.NB(NB)) chk_i (
  .clk(clk), .rst_n(rst_n), .ready_o(ready_o), .erasing_o(erasing_o),
  .tmr_exp_o(tmr_exp_o), .done_o(done_o), .err_o(err_o), .blk_fin(blk_fin)
);

// File: tb/mblk_erase_sched_tb_top.sv
`timescale 1ns/1ps
module mblk_erase_sched_tb_top;
  localparam int NB = 19;
  localparam int BW = $clog2(NB);
  localparam int CW = 16;
  localparam int WIN = 70;
  localparam int NOP = 100;

  logic clk = 1'b0, rst_n = 1'b0, tick_i = 1'b1;
  logic cfm_i = 1'b0, chip_i = 1'b0, susp_i = 1'b0, resume_i = 1'b0, fail_i = 1'b0;
  logic [BW-1:0] cfm_blk_i = '0;
  logic [NB-1:0] prot_i = '0;
  logic [CW-1:0] pre_ticks_i = CW'(3), ers_ticks_i = CW'(5);
  logic ready_o, tmr_exp_o, done_o, err_o;
  logic [NB-1:0] erasing_o;
  int errs = 0, checks = 0;

  always #10 clk = ~clk;

  mblk_erase_sched #(.NB(NB), .WIN_TICKS(WIN), .NOP_TICKS(NOP), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .cfm_i(cfm_i), .cfm_blk_i(cfm_blk_i),
    .chip_i(chip_i), .susp_i(susp_i), .resume_i(resume_i), .fail_i(fail_i),
    .prot_i(prot_i), .pre_ticks_i(pre_ticks_i), .ers_ticks_i(ers_ticks_i),
    .ready_o(ready_o), .erasing_o(erasing_o), .tmr_exp_o(tmr_exp_o),
    .done_o(done_o), .err_o(err_o)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_cfm(input int blk);
    cfm_i = 1'b1; cfm_blk_i = BW'(blk);
    @(negedge clk);
    cfm_i = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 ready", 32'(ready_o), 1);
    chk("R1 erasing", 32'(erasing_o), 0);
    chk("R1 tmr_exp", 32'(tmr_exp_o), 0);
    chk("R1 done/err", {30'd0, done_o, err_o}, 0);
  endtask

  task automatic t_single;
    do_cfm(3);
    chk("R2 ready low", 32'(ready_o), 0);
    chk("R2 erasing bit", 32'(erasing_o), 32'h8);
    chk("R3 tmr low in window", 32'(tmr_exp_o), 0);
    step(69); chk("R3 tmr one before expiry", 32'(tmr_exp_o), 0);
    step(1);  chk("R3 tmr at expiry", 32'(tmr_exp_o), 1);
    step(5);  chk("R4 block still pending", 32'(erasing_o), 32'h8);
    step(2);  chk("R4 not done early", 32'(done_o), 0);
    step(1);  chk("R11 done pulse", 32'(done_o), 1);
    chk("R11 idle at done", {30'd0, ready_o, |erasing_o}, 32'h2);
    step(1);  chk("R11 done one cycle", 32'(done_o), 0);
  endtask

  task automatic t_restart;
    do_cfm(9); step(29); do_cfm(2);
    chk("R3 two blocks gathered", 32'(erasing_o), 32'h204);
    step(69); chk("R3 window restarted", 32'(tmr_exp_o), 0);
    step(1);  chk("R3 expiry after restart", 32'(tmr_exp_o), 1);
    step(8);  chk("R4 lowest index first", 32'(erasing_o), 32'h200);
    step(7);  chk("R4 second not early", 32'(done_o), 0);
    step(1);  chk("R4 two blocks done", 32'(done_o), 1);
    step(1);
  endtask

  task automatic t_protect;
    prot_i = NB'(1) << 4;
    do_cfm(4); do_cfm(6);
    chk("R5 both selected in window", 32'(erasing_o), 32'h50);
    step(70); chk("R5 protected dropped", 32'(erasing_o), 32'h40);
    step(8);  chk("R5 skip costs no time", 32'(done_o), 1);
    step(1); prot_i = '0;
  endtask

  task automatic t_allprot;
    prot_i = NB'(1) << 7;
    do_cfm(7);
    step(70); chk("R6 busy with empty set", {29'd0, ready_o, tmr_exp_o, |erasing_o}, 32'h2);
    step(99); chk("R6 still busy", 32'(ready_o), 0);
    step(1);  chk("R6 idle after NOP ticks", {30'd0, done_o, ready_o}, 32'h3);
    step(1); prot_i = '0;
  endtask

  task automatic t_chip;
    prot_i = ~((NB'(1) << 18) | NB'(1));
    chip_i = 1'b1; @(negedge clk); chip_i = 1'b0;
    chk("R9 no window", {30'd0, tmr_exp_o, ready_o}, 32'h2);
    chk("R9 unprotected selected", 32'(erasing_o), 32'h40001);
    step(8);  chk("R9 first block finished", 32'(erasing_o), 32'h40000);
    step(8);  chk("R9 chip erase done", 32'(done_o), 1);
    step(1); prot_i = '0;
  endtask

  task automatic t_ignore;
    do_cfm(25);
    chk("R2 bad index ignored", {31'd0, ready_o}, 1);
    chk("R2 bad index no select", 32'(erasing_o), 0);
    step(1);
    do_cfm(1); step(70);
    cfm_i = 1'b1; cfm_blk_i = BW'(5); chip_i = 1'b1;
    step(1); cfm_i = 1'b0; chip_i = 1'b0;
    chk("R7 late requests ignored", 32'(erasing_o), 32'h2);
    step(7);  chk("R7 timing unchanged", 32'(done_o), 1);
    step(1);
  endtask

  task automatic t_susp;
    do_cfm(3); step(72);
    susp_i = 1'b1; step(1); susp_i = 1'b0;
    chk("R8 suspended ready", {30'd0, ready_o, tmr_exp_o}, 32'h3);
    chk("R8 selection held", 32'(erasing_o), 32'h8);
    step(20); chk("R8 no progress", {30'd0, ready_o, done_o}, 32'h2);
    resume_i = 1'b1; step(1); resume_i = 1'b0;
    chk("R8 resumed busy", 32'(ready_o), 0);
    step(5);  chk("R8 not done early", 32'(done_o), 0);
    step(1);  chk("R8 done after resume", 32'(done_o), 1);
    step(1);
  endtask

  task automatic t_susp_tick;
    do_cfm(3); step(75);
    tick_i = 1'b0; susp_i = 1'b1; step(1); susp_i = 1'b0;
    chk("R8 waits for tick", 32'(ready_o), 0);
    step(3); chk("R8 still waiting", 32'(ready_o), 0);
    tick_i = 1'b1; step(1);
    chk("R8 suspended at tick", 32'(ready_o), 1);
    resume_i = 1'b1; step(1); resume_i = 1'b0;
    chk("R8 resumed", 32'(ready_o), 0);
    step(2); chk("R8 erase not early", 32'(done_o), 0);
    step(1); chk("R8 erase phase continued", 32'(done_o), 1);
    step(1);
  endtask

  task automatic t_err;
    do_cfm(8); step(72);
    fail_i = 1'b1; step(1); fail_i = 1'b0;
    chk("R10 error set", 32'(err_o), 1);
    step(5); chk("R10 continues to done", {30'd0, done_o, err_o}, 32'h3);
    step(1); chk("R10 sticky in idle", 32'(err_o), 1);
    do_cfm(0);
    chk("R10 cleared on new erase", 32'(err_o), 0);
    step(78); chk("R10 clean run done", 32'(done_o), 1);
    step(1);
  endtask

  initial begin
    #200000;
    errs++; checks++;
    $display("FAIL watchdog expired (all requirements) act=running exp=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    step(4); rst_n = 1'b1; step(1);
    t_reset; t_single; t_restart; t_protect; t_allprot;
    t_chip; t_ignore; t_susp; t_susp_tick; t_err;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule